// File: doc/BRIEF.md
# SPI Configuration Slave with Status Byte

This block is the serial configuration port of a radio-style peripheral. A host microcontroller drives four SPI wires (data in, data out, clock, active-low select) in mode 0, MSB first. Within one select frame the host may issue any mix of command strobes, single-register writes or reads, burst register accesses and transmit-FIFO writes. Each access begins with a header byte: bit 7 selects read (1) or write (0), bit 6 selects burst, and bits 5:0 give the address.

While a header byte shifts in, the block shifts out a packed status byte. Bit 7 is an active-low ready flag. Bits 6:4 hold the main-state code taken from an input. Bits 3:0 hold the transmit-FIFO free-byte count, capped at 15. The state machine, the FIFO storage and the radio lie outside the block. It sees them only through the state, ready and free-count inputs, and it drives them through strobe pulses and a byte-wide FIFO write port. A register file of `NUM_REGS` bytes is held inside and is read back over SPI.

The SPI wires are brought into the system clock domain through two-stage synchronizers. The system clock must run at least eight times faster than the SPI clock.

Top module: `spiCfgSlave`

## Requirements
- R1: Status bit 7 is the inverse of `chipReady`: it reads 1 while the device is not ready and 0 once it is ready.
- R2: Status bits 6:4 copy `mainState`. The reserved input codes 001 and 110 are reported as 000.
- R3: Status bits 3:0 equal `fifoFree` when it is below 15, and 15 otherwise.
- R4: `spiSoOe` is high only while `spiCsN` is low. The first byte shifted out in each frame is the status byte, MSB first, with SO stable before each rising SCLK edge.
- R5: A header with bit 6 clear and address 0x30 to 0x3D is a strobe. It raises `strobePulse[addr-0x30]` for one clock, and strobes may follow each other back to back in one frame.
- R6: A header with bits 7:6 = 00 and address below `NUM_REGS` writes the next byte to that register. The byte after that is decoded as a new header, so address/data pairs may repeat in one frame.
- R7: A header with bits 7:6 = 10 makes the next byte shifted out the content of the addressed register.
- R8: A header with bit 6 set starts a burst. Each following byte writes (bit 7 = 0) or returns (bit 7 = 1) the register at an address one higher than the one before.
- R9: A write header to address 0x3F, with or without the burst bit, sends every following byte of the frame to the FIFO as a one-clock `fifoWrEn` pulse with the byte on `fifoWrData`.
- R10: A read header to address 0x3F produces no FIFO writes for any byte that follows it.
- R11: Raising `spiCsN` ends any burst or FIFO access. The first byte of the next frame is decoded as a header.
- R12: The status byte is also shifted out during each register-write data byte and each FIFO data byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| spiSclk | input | 1 | SPI clock, idle low |
| spiCsN | input | 1 | SPI select, active low |
| spiSi | input | 1 | SPI data from host |
| spiSo | output | 1 | SPI data to host |
| spiSoOe | output | 1 | Output enable for the SO pad driver |
| chipReady | input | 1 | High once power and clock are stable |
| mainState | input | 3 | Encoded main state |
| fifoFree | input | FREE_W | Free bytes in the transmit FIFO |
| fifoWrEn | output | 1 | One-clock FIFO push |
| fifoWrData | output | 8 | Byte pushed into the FIFO |
| strobePulse | output | 14 | One-hot command strobe pulses, bit i for address 0x30+i |

## Verification
The checker enforces three rules on every clock. At most one strobe line is high at a time. A strobe never coincides with a FIFO push. Every FIFO push or strobe directly follows a completed byte, and a FIFO push also requires select to have been low when that byte finished. The content of the status byte, the register contents seen through reads, the address stepping in bursts, the return to header decoding after select rises, and the mixing of access types in one frame depend on whole byte sequences. Only the bench's directed scenarios show these.

// File: rtl/spiCfgPkg.sv
package spiCfgPkg;
  localparam int HDR_ADDR_W = 6;
  localparam int NUM_STROBES = 14;
  localparam logic [HDR_ADDR_W-1:0] FIFO_ADDR = 6'h3F;
  localparam logic [HDR_ADDR_W-1:0] STROBE_FIRST = 6'h30;
  localparam logic [HDR_ADDR_W-1:0] STROBE_LAST = 6'h3D;

  typedef enum logic [1:0] {PH_HEADER, PH_SINGLE, PH_BURST, PH_FIFO} phase_t;

  typedef struct packed {
    logic nextStatus;
    logic nextRead;
    logic regWe;
    logic fifoWe;
    logic strobeFire;
    logic [HDR_ADDR_W-1:0] addr;
  } ctrlCmd_t;
endpackage

// File: rtl/spiCfgDatapath.sv
module spiCfgDatapath
  import spiCfgPkg::*;
#(
  parameter int NUM_REGS = 48,
  parameter int FREE_W = 7
) (
  input  logic clk,
  input  logic rstN,
  input  logic spiSclk,
  input  logic spiCsN,
  input  logic spiSi,
  input  logic chipReady,
  input  logic [2:0] mainState,
  input  logic [FREE_W-1:0] fifoFree,
  input  ctrlCmd_t cmd,
  output logic byteDone,
  output logic [7:0] rxByte,
  output logic frameActive,
  output logic spiSo,
  output logic fifoWrEn,
  output logic [7:0] fifoWrData,
  output logic [NUM_STROBES-1:0] strobePulse
);
  localparam int IDX_W = $clog2(NUM_REGS);

  logic [2:0] sclkSync;
  logic [2:0] csSync;
  logic [1:0] siSync;
  logic sclkRise, sclkFall, csFall;
  logic [2:0] bitCnt;
  logic [6:0] rxShift;
  logic [7:0] txShift, txNext;
  logic [7:0] statusByte, readByte;
  logic [2:0] stateCode;
  logic [3:0] freeSat;
  logic [7:0] regs [NUM_REGS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkSync <= '0;
      csSync <= '1;
      siSync <= '0;
    end else begin
      sclkSync <= {sclkSync[1:0], spiSclk};
      csSync <= {csSync[1:0], spiCsN};
      siSync <= {siSync[0], spiSi};
    end
  end

  assign sclkRise = sclkSync[1] & ~sclkSync[2];
  assign sclkFall = ~sclkSync[1] & sclkSync[2];
  assign frameActive = ~csSync[1];
  assign csFall = ~csSync[1] & csSync[2];

  always_comb begin
    unique case (mainState)
      3'b001, 3'b110: stateCode = 3'b000;
      default:        stateCode = mainState;
    endcase
    freeSat = (fifoFree > FREE_W'(15)) ? 4'hF : fifoFree[3:0];
    statusByte = {~chipReady, stateCode, freeSat};
    readByte = (int'(cmd.addr) < NUM_REGS) ? regs[cmd.addr[IDX_W-1:0]] : 8'h00;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
      rxShift <= '0;
      rxByte <= '0;
      byteDone <= 1'b0;
    end else begin
      byteDone <= 1'b0;
      if (!frameActive) begin
        bitCnt <= '0;
      end else if (sclkRise) begin
        bitCnt <= bitCnt + 3'd1;
        rxShift <= {rxShift[5:0], siSync[1]};
        if (bitCnt == 3'd7) begin
          byteDone <= 1'b1;
          rxByte <= {rxShift, siSync[1]};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
      txNext <= '0;
    end else begin
      if (csFall) txShift <= statusByte;
      else if (frameActive && sclkFall)
        txShift <= (bitCnt == 3'd0) ? txNext : {txShift[6:0], 1'b0};
      if (cmd.nextStatus) txNext <= statusByte;
      else if (cmd.nextRead) txNext <= readByte;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_REGS; i++) regs[i] <= '0;
    end else if (cmd.regWe && int'(cmd.addr) < NUM_REGS) begin
      regs[cmd.addr[IDX_W-1:0]] <= rxByte;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fifoWrEn <= 1'b0;
      fifoWrData <= '0;
    end else begin
      fifoWrEn <= cmd.fifoWe;
      if (cmd.fifoWe) fifoWrData <= rxByte;
    end
  end

  for (genvar s = 0; s < NUM_STROBES; s++) begin : gStrobe
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) strobePulse[s] <= 1'b0;
      else strobePulse[s] <= cmd.strobeFire && (cmd.addr == HDR_ADDR_W'(STROBE_FIRST + s));
    end
  end

  assign spiSo = txShift[7];
endmodule

// File: rtl/spiCfgControl.sv
module spiCfgControl
  import spiCfgPkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic byteDone,
  input  logic [7:0] rxByte,
  input  logic frameActive,
  output ctrlCmd_t cmd
);
  phase_t phase, phaseNxt;
  logic isRead, isReadNxt;
  logic [HDR_ADDR_W-1:0] addrQ, addrNxt;
  logic [HDR_ADDR_W-1:0] hdrAddr;
  logic isStrobe;

  assign hdrAddr = rxByte[HDR_ADDR_W-1:0];
  assign isStrobe = !rxByte[6] && hdrAddr >= STROBE_FIRST && hdrAddr <= STROBE_LAST;

  always_comb begin
    cmd = '0;
    cmd.addr = addrQ;
    phaseNxt = phase;
    isReadNxt = isRead;
    addrNxt = addrQ;
    if (byteDone) begin
      unique case (phase)
        PH_HEADER: begin
          isReadNxt = rxByte[7];
          addrNxt = hdrAddr;
          cmd.addr = hdrAddr;
          if (hdrAddr == FIFO_ADDR) begin
            phaseNxt = PH_FIFO;
            cmd.nextStatus = 1'b1;
          end else if (isStrobe) begin
            cmd.strobeFire = 1'b1;
            cmd.nextStatus = 1'b1;
          end else begin
            phaseNxt = rxByte[6] ? PH_BURST : PH_SINGLE;
            cmd.nextRead = rxByte[7];
            cmd.nextStatus = !rxByte[7];
          end
        end
        PH_SINGLE: begin
          cmd.regWe = !isRead;
          cmd.nextStatus = 1'b1;
          phaseNxt = PH_HEADER;
        end
        PH_BURST: begin
          cmd.regWe = !isRead;
          addrNxt = addrQ + 1'b1;
          cmd.addr = isRead ? addrNxt : addrQ;
          cmd.nextRead = isRead;
          cmd.nextStatus = !isRead;
        end
        PH_FIFO: begin
          cmd.fifoWe = !isRead;
          cmd.nextStatus = 1'b1;
        end
        default: phaseNxt = PH_HEADER;
      endcase
    end
    if (!frameActive) phaseNxt = PH_HEADER;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= PH_HEADER;
      isRead <= 1'b0;
      addrQ <= '0;
    end else begin
      phase <= phaseNxt;
      isRead <= isReadNxt;
      addrQ <= addrNxt;
    end
  end
endmodule

// File: rtl/spiCfgSlave.sv
module spiCfgSlave
  import spiCfgPkg::*;
#(
  parameter int NUM_REGS = 48,
  parameter int FREE_W = 7
) (
  input  logic clk,
  input  logic rstN,
  input  logic spiSclk,
  input  logic spiCsN,
  input  logic spiSi,
  output logic spiSo,
  output logic spiSoOe,
  input  logic chipReady,
  input  logic [2:0] mainState,
  input  logic [FREE_W-1:0] fifoFree,
  output logic fifoWrEn,
  output logic [7:0] fifoWrData,
  output logic [NUM_STROBES-1:0] strobePulse
);
  ctrlCmd_t cmd;
  logic byteDone;
  logic [7:0] rxByte;
  logic frameActive;

  spiCfgDatapath #(.NUM_REGS(NUM_REGS), .FREE_W(FREE_W)) uDatapath (
    .clk(clk), .rstN(rstN),
    .spiSclk(spiSclk), .spiCsN(spiCsN), .spiSi(spiSi),
    .chipReady(chipReady), .mainState(mainState), .fifoFree(fifoFree),
    .cmd(cmd), .byteDone(byteDone), .rxByte(rxByte), .frameActive(frameActive),
    .spiSo(spiSo), .fifoWrEn(fifoWrEn), .fifoWrData(fifoWrData),
    .strobePulse(strobePulse)
  );

  spiCfgControl uControl (
    .clk(clk), .rstN(rstN),
    .byteDone(byteDone), .rxByte(rxByte), .frameActive(frameActive),
    .cmd(cmd)
  );

  assign spiSoOe = ~spiCsN;
endmodule

// File: rtl/spiCfgChecker.sv
module spiCfgChecker
  import spiCfgPkg::*;
(
  input logic clk,
  input logic rstN,
  input logic spiCsN,
  input logic byteDone,
  input logic fifoWrEn,
  input logic [NUM_STROBES-1:0] strobePulse
);
  AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobePulse)); // R5

  AST_STROBE_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rstN)
    (|strobePulse) |-> $past(byteDone)); // R5

  AST_FIFO_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rstN)
    fifoWrEn |-> $past(byteDone)); // R9

  AST_FIFO_IN_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    fifoWrEn |-> !$past(spiCsN, 4)); // R11

  AST_FIFO_NOT_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    fifoWrEn |-> (strobePulse == '0)); // R9
endmodule

bind spiCfgSlave spiCfgChecker uChk (
  .clk(clk), .rstN(rstN), .spiCsN(spiCsN), .byteDone(byteDone),
  .fifoWrEn(fifoWrEn), .strobePulse(strobePulse)
);

// File: tb/spiCfgSlave_test.sv
module spiCfgSlave_test;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 5;
  localparam int FREE_W = 7;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic spiSclk = 1'b0, spiCsN = 1'b1, spiSi = 1'b0;
  logic spiSo, spiSoOe;
  logic chipReady = 1'b1;
  logic [2:0] mainState = 3'b000;
  logic [FREE_W-1:0] fifoFree = '0;
  logic fifoWrEn;
  logic [7:0] fifoWrData;
  logic [13:0] strobePulse;

  int checks = 0, errors = 0;
  logic [7:0] fifoLog [32];
  int fifoCnt = 0;
  int strobeLog [32];
  int strobeCnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spiCfgSlave #(.NUM_REGS(48), .FREE_W(FREE_W)) uut (
    .clk(clk), .rstN(rstN), .spiSclk(spiSclk), .spiCsN(spiCsN), .spiSi(spiSi),
    .spiSo(spiSo), .spiSoOe(spiSoOe), .chipReady(chipReady), .mainState(mainState),
    .fifoFree(fifoFree), .fifoWrEn(fifoWrEn), .fifoWrData(fifoWrData),
    .strobePulse(strobePulse)
  );

  always @(posedge clk) begin
    if (rstN) begin
      if (fifoWrEn && fifoCnt < 32) begin
        fifoLog[fifoCnt] = fifoWrData;
        fifoCnt++;
      end
      for (int i = 0; i < 14; i++)
        if (strobePulse[i] && strobeCnt < 32) begin
          strobeLog[strobeCnt] = i;
          strobeCnt++;
        end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic csLow();
    spiCsN = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic csHigh();
    repeat (HALF) @(negedge clk);
    spiCsN = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic spiByte(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      spiSi = tx[i];
      repeat (HALF) @(negedge clk);
      rx[i] = spiSo;
      spiSclk = 1'b1;
      repeat (HALF) @(negedge clk);
      spiSclk = 1'b0;
    end
  endtask

  task automatic statusCase(input logic rdy, input logic [2:0] st, input int freeN,
                            input logic [7:0] exp, input string req);
    logic [7:0] rx;
    chipReady = rdy;
    mainState = st;
    fifoFree = FREE_W'(freeN);
    csLow();
    check("R4 oe while selected", int'(spiSoOe), 1);
    spiByte(8'h80, rx);
    check(req, int'(rx), int'(exp));
    csHigh();
    check("R4 oe released", int'(spiSoOe), 0);
  endtask

  task automatic testReset();
    check("R4 reset oe", int'(spiSoOe), 0);
    check("R9 reset fifo", int'(fifoWrEn), 0);
    check("R5 reset strobe", int'(strobePulse), 0);
  endtask

  task automatic testStatus();
    statusCase(1'b0, 3'b010, 5, 8'hA5, "R1 R2 R3 not ready tx");
    statusCase(1'b1, 3'b110, 100, 8'h0F, "R2 reserved 110 R3 saturate");
    statusCase(1'b1, 3'b001, 0, 8'h00, "R2 reserved 001");
    statusCase(1'b1, 3'b111, 15, 8'h7F, "R2 underflow R3 fifteen");
    statusCase(1'b1, 3'b011, 16, 8'h3F, "R3 sixteen saturates");
    statusCase(1'b1, 3'b101, 14, 8'h5E, "R2 settling R3 fourteen");
    mainState = 3'b000;
    fifoFree = FREE_W'(9);
  endtask

  task automatic testSingle();
    logic [7:0] rx;
    csLow();
    spiByte(8'h05, rx);
    spiByte(8'h5A, rx);
    check("R12 status on write data", int'(rx), 8'h09);
    spiByte(8'h06, rx);
    check("R6 pair repeats header status", int'(rx), 8'h09);
    spiByte(8'hC3, rx);
    csHigh();
    csLow();
    spiByte(8'h85, rx);
    spiByte(8'h00, rx);
    check("R7 R6 read reg5", int'(rx), 8'h5A);
    spiByte(8'h86, rx);
    spiByte(8'h00, rx);
    check("R7 R6 read reg6", int'(rx), 8'hC3);
    csHigh();
  endtask

  task automatic testBurst();
    logic [7:0] rx;
    logic [7:0] vals [4] = '{8'h11, 8'h22, 8'h33, 8'h44};
    csLow();
    spiByte(8'h50, rx);
    for (int i = 0; i < 4; i++) spiByte(vals[i], rx);
    csHigh();
    csLow();
    spiByte(8'hD0, rx);
    for (int i = 0; i < 4; i++) begin
      spiByte(8'h00, rx);
      check("R8 burst read", int'(rx), int'(vals[i]));
    end
    csHigh();
  endtask

  task automatic readReg(input logic [5:0] a, output logic [7:0] v);
    logic [7:0] rx;
    csLow();
    spiByte({2'b10, a}, rx);
    spiByte(8'h00, v);
    csHigh();
  endtask

  task automatic testCsEndsBurst();
    logic [7:0] rx, v;
    csLow();
    spiByte(8'h50, rx);
    spiByte(8'h77, rx);
    csHigh();
    csLow();
    spiByte(8'h14, rx);
    spiByte(8'h99, rx);
    csHigh();
    readReg(6'h10, v);
    check("R8 burst rewrite reg10", int'(v), 8'h77);
    readReg(6'h11, v);
    check("R11 reg11 untouched", int'(v), 8'h22);
    readReg(6'h12, v);
    check("R11 reg12 untouched", int'(v), 8'h33);
    readReg(6'h14, v);
    check("R11 new frame header", int'(v), 8'h99);
  endtask

  task automatic testStrobes();
    logic [7:0] rx;
    strobeCnt = 0;
    csLow();
    spiByte(8'h30, rx);
    spiByte(8'h3B, rx);
    check("R12 R5 status during strobe", int'(rx), 8'h09);
    spiByte(8'h3D, rx);
    csHigh();
    check("R5 strobe count", strobeCnt, 3);
    check("R5 strobe first", strobeLog[0], 0);
    check("R5 strobe flush", strobeLog[1], 11);
    check("R5 strobe last", strobeLog[2], 13);
  endtask

  task automatic testFifo();
    logic [7:0] rx;
    fifoCnt = 0;
    csLow();
    spiByte(8'h3F, rx);
    spiByte(8'hA1, rx);
    spiByte(8'hB2, rx);
    check("R12 status on fifo byte", int'(rx), 8'h09);
    spiByte(8'hC3, rx);
    csHigh();
    csLow();
    spiByte(8'h7F, rx);
    spiByte(8'hD4, rx);
    csHigh();
    check("R9 fifo count", fifoCnt, 4);
    check("R9 fifo byte0", int'(fifoLog[0]), 8'hA1);
    check("R9 fifo byte2", int'(fifoLog[2]), 8'hC3);
    check("R9 fifo burst header", int'(fifoLog[3]), 8'hD4);
    csLow();
    spiByte(8'hBF, rx);
    spiByte(8'h12, rx);
    spiByte(8'h34, rx);
    csHigh();
    check("R10 fifo read pushes nothing", fifoCnt, 4);
  endtask

  task automatic testMixed();
    logic [7:0] rx, v;
    fifoCnt = 0;
    strobeCnt = 0;
    csLow();
    spiByte(8'h02, rx);
    spiByte(8'h44, rx);
    spiByte(8'h36, rx);
    spiByte(8'h3F, rx);
    spiByte(8'hEE, rx);
    spiByte(8'hFF, rx);
    csHigh();
    readReg(6'h02, v);
    check("R6 mixed reg write", int'(v), 8'h44);
    check("R5 mixed strobe count", strobeCnt, 1);
    check("R5 mixed strobe index", strobeLog[0], 6);
    check("R9 mixed fifo count", fifoCnt, 2);
    check("R9 mixed fifo last", int'(fifoLog[1]), 8'hFF);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (4) @(negedge clk);
    testReset();
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    testStatus();
    testSingle();
    testBurst();
    testCsEndsBurst();
    testStrobes();
    testFifo();
    testMixed();
    summary();
  end
endmodule